// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus. It walks the memory through its mandatory start-up script. Clocks, power rails, the PHY and normal read and write scheduling are outside it. After a synchronous reset it keeps the clock enable low for a programmable settling interval. It then raises the clock enable, drives one NOP, and issues a fixed series of commands. The series is a precharge of all banks, an extended mode load, a mode load with the DLL reset bit set, a second precharge of all banks, two auto refreshes and, if enabled, a closing mode load that clears the DLL reset bit. Every gap between commands is filled with NOPs and timed by a down-counter.

Three configuration inputs shape the script. One selects normal or reduced output drive. One moves the two refreshes ahead of the second precharge. One enables the closing mode load. A second counter starts when the DLL reset is loaded. `read_allowed` stays low until that lock interval has run out and the script is complete. `init_done` marks the point where any command may be driven. All command, address and bank outputs are decoded from the registered state, so each of them changes on the clock edge after the decision is made. There is no data stream at the block's edges: the inputs are static configuration levels and the outputs are plain status and command pins.

Top module: `ddr_init_seq`

## Requirements
- R1: Counting the first cycle after the reset edge as cycle 0, cycles 0 to T_STAB-1 drive cke=0 and the NOP command ({cs_n,ras_n,cas_n,we_n}=0111, ba=0, addr=0), with init_done=0 and read_allowed=0.
- R2: cke rises in cycle T_STAB with a NOP on the bus, and it stays high until the next reset.
- R3: Command codes on {cs_n,ras_n,cas_n,we_n} are: precharge 0010 with addr bit 10 set and all other address bits zero; auto refresh 0001 with addr=0; mode load 0000. In the default order the commands follow one another as precharge, extended load, DLL-reset load, precharge, refresh, refresh. The first precharge falls in cycle T_STAB+1.
- R4: The spacing from one command to the next is exactly T_RP cycles after a precharge, T_MRD after a mode load and T_RFC after a refresh. Every cycle between two commands is a NOP.
- R5: The extended load drives ba=01, addr bit 0 = 0 (DLL enabled), addr bit 1 = cfg_reduced_drive, and all other address bits 0.
- R6: The DLL-reset load drives ba=00 and addr=cfg_mode with bit 8 forced to 1.
- R7: With cfg_refresh_first=1, both refreshes follow the DLL-reset load, and the second precharge follows the second refresh.
- R8: With cfg_final_load=1, a last mode load with ba=00 and addr=cfg_mode with bit 8 forced to 0 follows the last step of the script. With cfg_final_load=0 no such command is issued.
- R9: init_done rises in the cycle a further command would be allowed after the last command's gap. It then stays high, and only NOP with cke=1 is driven, until reset.
- R10: read_allowed is high exactly in the cycles where init_done is high and at least T_DLL cycles have passed since the DLL-reset load.
- R11: A reset asserted in the middle of the script returns the block to the R1 state in the following cycle and restarts the script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | ADDR_W | Operating parameters for the mode register loads |
| cfg_reduced_drive | input | 1 | 1 selects reduced output drive in the extended load |
| cfg_refresh_first | input | 1 | 1 places the two refreshes before the second precharge |
| cfg_final_load | input | 1 | 1 enables the closing mode load that clears the DLL reset bit |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | Initialization complete |
| read_allowed | output | 1 | READ commands may be issued |

## Verification
From the configuration inputs and the timing parameters, the bench works out the exact cycle of every command, the cycle where init_done rises, and that cycle or the DLL lock cycle, whichever is later, for read_allowed. Cycle numbers count from the first cycle after the reset edge. It then compares the whole command bus, cke and both flags against that schedule on the falling edge of every cycle. Because every output is decoded from registered state with no extra stage, a result due in cycle k is sampled in the half period before edge k+1. The sweep covers all eight configuration combinations, uses timing values under which either init_done or the DLL lock is the later event, and includes one reset that cuts a run short in the middle of the script.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [4:0] {
    ST_STAB,
    ST_NOP,
    ST_PRE1,
    ST_W_PRE1,
    ST_EMR,
    ST_W_EMR,
    ST_MR1,
    ST_W_MR1,
    ST_PRE2,
    ST_W_PRE2,
    ST_REF1,
    ST_W_REF1,
    ST_REF2,
    ST_W_REF2,
    ST_MR2,
    ST_W_MR2,
    ST_DONE
  } init_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  localparam int ALL_BANK_BIT = 10;
  localparam int DLL_RST_BIT  = 8;

endpackage

// File: rtl/ddr_init_down_cnt.sv
module ddr_init_down_cnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= W'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  init_state_e       state,
  input  logic [ADDR_W-1:0] cfg_mode,
  input  logic              cfg_reduced_drive,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);

  logic [3:0]        cmd;
  logic [ADDR_W-1:0] mode_set, mode_clr, ext_val, pre_val;

  always_comb begin
    mode_set = cfg_mode;
    mode_set[DLL_RST_BIT] = 1'b1;
    mode_clr = cfg_mode;
    mode_clr[DLL_RST_BIT] = 1'b0;
    ext_val = '0;
    ext_val[1] = cfg_reduced_drive;
    pre_val = '0;
    pre_val[ALL_BANK_BIT] = 1'b1;
  end

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    unique case (state)
      ST_PRE1, ST_PRE2: begin cmd = CMD_PRE; addr = pre_val; end
      ST_REF1, ST_REF2: cmd = CMD_REF;
      ST_EMR:           begin cmd = CMD_LMR; addr = ext_val; ba = BA_W'(1); end
      ST_MR1:           begin cmd = CMD_LMR; addr = mode_set; end
      ST_MR2:           begin cmd = CMD_LMR; addr = mode_clr; end
      default:          cmd = CMD_NOP;
    endcase
  end

  assign cke = (state != ST_STAB);
  assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int T_STAB = 25000,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 10,
  parameter int T_DLL  = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_mode,
  input  logic              cfg_reduced_drive,
  input  logic              cfg_refresh_first,
  input  logic              cfg_final_load,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done,
  output logic              read_allowed
);

  localparam int MAX_A  = (T_STAB > T_DLL) ? T_STAB : T_DLL;
  localparam int MAX_B  = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int MAX_C  = (MAX_B > T_MRD) ? MAX_B : T_MRD;
  localparam int MAX_V  = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W  = $clog2(MAX_V + 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 2);
  localparam logic [CNT_W-1:0] LD_DLL = CNT_W'(T_DLL - 1);

  init_state_e      state_q, state_d;
  logic             gap_load, gap_zero;
  logic [CNT_W-1:0] gap_val;
  logic             dll_load, dll_zero, dll_armed_q;
  init_state_e      after_mr1, after_pre2, after_ref2, tail;

  always_comb begin
    tail       = cfg_final_load ? ST_MR2 : ST_DONE;
    after_mr1  = cfg_refresh_first ? ST_REF1 : ST_PRE2;
    after_pre2 = cfg_refresh_first ? tail : ST_REF1;
    after_ref2 = cfg_refresh_first ? ST_PRE2 : tail;
  end

  always_comb begin
    state_d  = state_q;
    gap_load = 1'b0;
    gap_val  = '0;
    unique case (state_q)
      ST_STAB:   if (gap_zero) state_d = ST_NOP;
      ST_NOP:    state_d = ST_PRE1;
      ST_PRE1:   begin gap_load = 1'b1; gap_val = LD_RP;  state_d = ST_W_PRE1; end
      ST_W_PRE1: if (gap_zero) state_d = ST_EMR;
      ST_EMR:    begin gap_load = 1'b1; gap_val = LD_MRD; state_d = ST_W_EMR; end
      ST_W_EMR:  if (gap_zero) state_d = ST_MR1;
      ST_MR1:    begin gap_load = 1'b1; gap_val = LD_MRD; state_d = ST_W_MR1; end
      ST_W_MR1:  if (gap_zero) state_d = after_mr1;
      ST_PRE2:   begin gap_load = 1'b1; gap_val = LD_RP;  state_d = ST_W_PRE2; end
      ST_W_PRE2: if (gap_zero) state_d = after_pre2;
      ST_REF1:   begin gap_load = 1'b1; gap_val = LD_RFC; state_d = ST_W_REF1; end
      ST_W_REF1: if (gap_zero) state_d = ST_REF2;
      ST_REF2:   begin gap_load = 1'b1; gap_val = LD_RFC; state_d = ST_W_REF2; end
      ST_W_REF2: if (gap_zero) state_d = after_ref2;
      ST_MR2:    begin gap_load = 1'b1; gap_val = LD_MRD; state_d = ST_W_MR2; end
      ST_W_MR2:  if (gap_zero) state_d = ST_DONE;
      default:   state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_STAB;
    else     state_q <= state_d;
  end

  ddr_init_down_cnt #(.W(CNT_W), .RST_VAL(T_STAB - 1)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  assign dll_load = (state_q == ST_MR1);

  ddr_init_down_cnt #(.W(CNT_W), .RST_VAL(0)) u_dll (
    .clk(clk), .rst(rst), .load(dll_load), .load_val(LD_DLL), .zero(dll_zero)
  );

  always_ff @(posedge clk) begin
    if (rst)           dll_armed_q <= 1'b0;
    else if (dll_load) dll_armed_q <= 1'b1;
  end

  ddr_init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .state(state_q), .cfg_mode(cfg_mode), .cfg_reduced_drive(cfg_reduced_drive),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba)
  );

  assign init_done    = (state_q == ST_DONE);
  assign read_allowed = init_done && dll_armed_q && dll_zero;

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              init_done,
  input logic              read_allowed
);

  logic is_nop, is_pre, is_ext;
  assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
  assign is_ext = ({cs_n, ras_n, cas_n, we_n} == 4'b0000) && (ba == BA_W'(1));

  a_r1_low_cke_nop: assert property (@(posedge clk) disable iff (rst)
    !cke |-> is_nop);

  a_r2_cke_holds: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  a_r2_first_nop: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> is_nop);

  a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> addr[10]);

  a_r4_nop_after_cmd: assert property (@(posedge clk) disable iff (rst)
    !is_nop |=> is_nop);

  a_r5_ext_bits: assert property (@(posedge clk) disable iff (rst)
    is_ext |-> (addr[0] == 1'b0) && ((addr >> 2) == '0));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop && cke);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  a_r10_read_gated: assert property (@(posedge clk) disable iff (rst)
    read_allowed |-> init_done);

  a_r10_read_sticky: assert property (@(posedge clk) disable iff (rst)
    read_allowed |=> read_allowed);

endmodule

bind ddr_init_seq ddr_init_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ba(ba), .init_done(init_done),
  .read_allowed(read_allowed)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;

  localparam int AW   = 13;
  localparam int TS   = 8;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int TRFC = 8;
  localparam int TDLL = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] cfg_mode = '0;
  logic cfg_red = 1'b0, cfg_rf = 1'b0, cfg_fin = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, read_allowed;
  logic [AW-1:0] addr;
  logic [1:0] ba;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_init_seq #(.ADDR_W(AW), .BA_W(2), .T_STAB(TS), .T_RP(TRP),
                 .T_MRD(TMRD), .T_RFC(TRFC), .T_DLL(TDLL)) u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_reduced_drive(cfg_red),
    .cfg_refresh_first(cfg_rf), .cfg_final_load(cfg_fin),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done), .read_allowed(read_allowed)
  );

  // bus word: {cmd[3:0], ba[1:0], addr[12:0]}
  localparam logic [18:0] W_NOP = {4'b0111, 2'b00, 13'h0};
  localparam logic [18:0] W_PRE = {4'b0010, 2'b00, 13'h400};
  localparam logic [18:0] W_REF = {4'b0001, 2'b00, 13'h0};

  int          s_t [0:7];
  logic [18:0] s_w [0:7];
  string       s_r [0:7];
  int n_cmd, t_mr1, t_done;

  task automatic add_cmd(int t, logic [18:0] w, string r);
    s_t[n_cmd] = t; s_w[n_cmd] = w; s_r[n_cmd] = r; n_cmd++;
  endtask

  task automatic build();
    int t;
    string rr;
    rr = cfg_rf ? "R7" : "R3";
    n_cmd = 0;
    t = TS + 1;
    add_cmd(t, W_PRE, "R3"); t += TRP;
    add_cmd(t, {4'b0000, 2'b01, 11'h0, cfg_red, 1'b0}, "R5"); t += TMRD;
    t_mr1 = t;
    add_cmd(t, {4'b0000, 2'b00, cfg_mode | 13'h100}, "R6"); t += TMRD;
    if (!cfg_rf) begin
      add_cmd(t, W_PRE, rr); t += TRP;
      add_cmd(t, W_REF, rr); t += TRFC;
      add_cmd(t, W_REF, rr); t += TRFC;
    end else begin
      add_cmd(t, W_REF, rr); t += TRFC;
      add_cmd(t, W_REF, rr); t += TRFC;
      add_cmd(t, W_PRE, rr); t += TRP;
    end
    if (cfg_fin) begin
      add_cmd(t, {4'b0000, 2'b00, cfg_mode & ~13'h100}, "R8"); t += TMRD;
    end
    t_done = t;
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // run one configuration; ncyc < 0 means run to completion
  task automatic run(int ncyc, bit after_abort);
    int last;
    logic [18:0] ew, aw;
    string tag;
    bit eid, era;
    build();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    last = (ncyc < 0) ? (t_done + TDLL + 4) : ncyc;
    for (int k = 0; k <= last; k++) begin
      ew  = W_NOP;
      tag = (k < TS) ? "R1" : "R4";
      for (int i = 0; i < n_cmd; i++)
        if (s_t[i] == k) begin ew = s_w[i]; tag = s_r[i]; end
      if (k > t_done - 1 && ew == W_NOP) tag = "R9";
      aw = {cs_n, ras_n, cas_n, we_n, ba, addr};
      if (after_abort && k == 0)
        check(cke == 1'b0 && !init_done && aw == W_NOP, "R11", "restart state",
              {12'h0, cke, init_done, aw}, {13'h0, 19'(W_NOP)});
      check(cke == (k >= TS), (k < TS) ? "R1" : "R2", "cke", cke, (k >= TS));
      check(aw == ew, tag, "bus", aw, ew);
      eid = (k >= t_done);
      era = eid && (k >= t_mr1 + TDLL);
      check(init_done == eid, "R9", "init_done", init_done, eid);
      check(read_allowed == era, "R10", "read_allowed", read_allowed, era);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      cfg_rf   = c[0];
      cfg_fin  = c[1];
      cfg_red  = c[2];
      cfg_mode = 13'h0032 ^ 13'(c * 13'h211);
      if (c == 5) begin
        run(TS + 12, 1'b0);
        run(-1, 1'b1);
      end else begin
        run(-1, 1'b0);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule